// File: doc/BRIEF.md
# Oscillator Clock Activity Monitor

This block watches a fast monitored oscillator clock from a slower, trusted reference clock and reports when the oscillator stops toggling. Rising and falling edges of the monitored clock are each caught by a toggle-and-acknowledge handshake in the monitored clock's own domain, so a burst of edges can never cancel itself out. The reference domain sees each handshake step as a single-cycle "seen" pulse and gathers these pulses over fixed observation windows. A window that lacks either edge type is a failed window.

The monitor judges windows only while the oscillator is enabled, requested and awake, and while software has enabled monitoring. Each time monitoring (re)starts, a programmable blanking interval counted in reference cycles must pass before any window is judged. The live failure status follows the most recent window verdict. A sticky interrupt flag records every failed window until software clears it. An optional interrupt line and an optional one-cycle event pulse are derived from these. The event is suppressed while the system already runs from the safe clock.

Top module: `osc_activity_monitor`

## Requirements
- R1: After reset, `fail_status_o`, `irq_flag_o`, `irq_o` and `evt_o` are 0. No window is judged while `mon_en` is 0.
- R2: While `osc_en` is 0, no window is judged, `fail_status_o` is held at 0 and `irq_flag_o` is not set.
- R3: While `osc_req` is 0 (oscillator not requested or halted for sleep), monitoring is suspended as in R2. A return to 1 counts as a new start.
- R4: On each start (rise of `osc_en & mon_en & osc_req`), `startup_cnt` is loaded. No window is judged, and `fail_status_o` cannot rise, until that many reference cycles have passed.
- R5: After blanking, windows of `WIN_CYCLES` (4) reference cycles run back to back. A window is healthy only if at least one rising and one falling edge of `mon_clk` were seen in it.
- R6: A failed window sets `fail_status_o` to 1 and sets `irq_flag_o`.
- R7: Monitoring continues after a failure. `fail_status_o` returns to 0 at the first healthy window, while `irq_flag_o` stays set.
- R8: A 1 on `flag_clr` clears `irq_flag_o` on the next reference edge. If a failed window ends in the same cycle, the flag stays set.
- R9: `irq_o` is 1 exactly when `irq_flag_o` is 1 and `irq_en` is 1.
- R10: When `evt_en` is 1, `evt_o` pulses for one reference cycle, in the same cycle in which `fail_status_o` rises.
- R11: No event pulse is produced while `on_safe_clk` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Trusted reference clock; all outputs are in this domain |
| ref_rst_n | input | 1 | Asynchronous active-low reset for both domains |
| mon_clk | input | 1 | Monitored oscillator clock |
| osc_en | input | 1 | Oscillator enabled |
| mon_en | input | 1 | Monitoring enabled by software |
| osc_req | input | 1 | Oscillator requested and not halted for sleep |
| startup_cnt | input | STARTUP_W | Blanking interval in reference cycles after each start |
| irq_en | input | 1 | Interrupt line enable |
| evt_en | input | 1 | Event pulse enable |
| on_safe_clk | input | 1 | System currently runs from the safe clock |
| flag_clr | input | 1 | Write-one-to-clear strobe for the interrupt flag |
| fail_status_o | output | 1 | Live verdict of the latest window (1 = failing) |
| irq_flag_o | output | 1 | Sticky failure flag |
| irq_o | output | 1 | Interrupt request |
| evt_o | output | 1 | One-cycle failure event |

## Verification
The bench builds the block with `WIN_CYCLES` = 4, `STARTUP_W` = 8 and two synchronizer stages. The monitored clock runs at about 2.7 times the reference rate, so the handshake round trip stays inside one window. The 8-bit start-up field allows a 40-cycle blanking test, in which the result is sampled both inside and after the interval. Stopping and restarting the monitored clock through a gate drives the status through failure and recovery. This covers the interrupt and event gating under each combination of enables and the safe-clock indication.

// File: rtl/oam_pkg.sv
package oam_pkg;
    // Which monitored-clock edge an edge catcher responds to
    typedef enum logic {
        EDGE_RISE = 1'b0,
        EDGE_FALL = 1'b1
    } oam_edge_e;
endpackage

// File: rtl/oam_edge_catcher.sv
// Monitored-clock domain: flips a toggle once per acknowledged edge.
// The toggle only moves when the reference side has acknowledged the
// previous value, so bursts of edges cannot cancel each other.
module oam_edge_catcher #(
    parameter oam_pkg::oam_edge_e EDGE = oam_pkg::EDGE_RISE,
    parameter int SYNC_STAGES = 2
) (
    input  logic mon_clk,
    input  logic rst_n,
    input  logic ack_i,
    output logic tgl_o
);
    logic clk_sel;
    assign clk_sel = (EDGE == oam_pkg::EDGE_FALL) ? ~mon_clk : mon_clk;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] ack_sync;
        logic                   tgl;
    } cst_t;

    cst_t cq, cd;

    always_comb begin
        cd          = cq;
        cd.ack_sync = {cq.ack_sync[SYNC_STAGES-2:0], ack_i};
        if (cq.tgl == cq.ack_sync[SYNC_STAGES-1])
            cd.tgl = ~cq.tgl;
    end

    always_ff @(posedge clk_sel or negedge rst_n) begin
        if (!rst_n) cq <= '0;
        else        cq <= cd;
    end

    assign tgl_o = cq.tgl;
endmodule

// File: rtl/oam_ref_tracker.sv
// Reference domain: synchronizes one toggle, acknowledges it and emits a
// one-cycle pulse for every step of the handshake.
module oam_ref_tracker #(
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk,
    input  logic rst_n,
    input  logic tgl_i,
    output logic ack_o,
    output logic seen_o
);
    typedef struct packed {
        logic [SYNC_STAGES-1:0] sync;
        logic                   ack;
    } tst_t;

    tst_t tq, td;

    always_comb begin
        td      = tq;
        td.sync = {tq.sync[SYNC_STAGES-2:0], tgl_i};
        td.ack  = tq.sync[SYNC_STAGES-1];
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) tq <= '0;
        else        tq <= td;
    end

    assign ack_o  = tq.ack;
    assign seen_o = tq.sync[SYNC_STAGES-1] ^ tq.ack;

    // R5: a handshake step cannot repeat in back-to-back cycles
    seen_single_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        seen_o |=> !seen_o);
endmodule

// File: rtl/osc_activity_monitor.sv
module osc_activity_monitor #(
    parameter int WIN_CYCLES  = 4,
    parameter int STARTUP_W   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 ref_clk,
    input  logic                 ref_rst_n,
    input  logic                 mon_clk,
    input  logic                 osc_en,
    input  logic                 mon_en,
    input  logic                 osc_req,
    input  logic [STARTUP_W-1:0] startup_cnt,
    input  logic                 irq_en,
    input  logic                 evt_en,
    input  logic                 on_safe_clk,
    input  logic                 flag_clr,
    output logic                 fail_status_o,
    output logic                 irq_flag_o,
    output logic                 irq_o,
    output logic                 evt_o
);
    localparam int WIN_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_CYCLES - 1);
    localparam int N_EDGE = 2;

    logic [N_EDGE-1:0] tgl, ack, seen;

    for (genvar g = 0; g < N_EDGE; g++) begin : g_edge
        oam_edge_catcher #(
            .EDGE        ((g == 0) ? oam_pkg::EDGE_RISE : oam_pkg::EDGE_FALL),
            .SYNC_STAGES (SYNC_STAGES)
        ) catch_i (
            .mon_clk (mon_clk),
            .rst_n   (ref_rst_n),
            .ack_i   (ack[g]),
            .tgl_o   (tgl[g])
        );
        oam_ref_tracker #(
            .SYNC_STAGES (SYNC_STAGES)
        ) track_i (
            .ref_clk (ref_clk),
            .rst_n   (ref_rst_n),
            .tgl_i   (tgl[g]),
            .ack_o   (ack[g]),
            .seen_o  (seen[g])
        );
    end

    typedef struct packed {
        logic                 run;
        logic [STARTUP_W-1:0] blank;
        logic [WIN_W-1:0]     win;
        logic [N_EDGE-1:0]    got;
        logic                 fail;
        logic                 flag;
        logic                 evt;
    } st_t;

    st_t  q, d;
    logic run_now, boundary, window_bad;

    always_comb begin
        run_now    = osc_en & mon_en & osc_req;
        boundary   = run_now && q.run && (q.blank == '0) && (q.win == WIN_LAST);
        window_bad = boundary && !(&(q.got | seen));

        d     = q;
        d.run = run_now;
        if (!run_now) begin
            d.win   = '0;
            d.got   = '0;
            d.fail  = 1'b0;
        end else if (!q.run) begin
            // a fresh start: reload the blanking interval
            d.blank = startup_cnt;
            d.win   = '0;
            d.got   = '0;
        end else if (q.blank != '0) begin
            d.blank = q.blank - 1'b1;
            d.win   = '0;
            d.got   = '0;
        end else if (boundary) begin
            d.win   = '0;
            d.got   = '0;
            d.fail  = window_bad;
        end else begin
            d.win   = q.win + 1'b1;
            d.got   = q.got | seen;
        end

        d.flag = window_bad | (q.flag & ~flag_clr);
        d.evt  = window_bad & ~q.fail & evt_en & ~on_safe_clk;
    end

    always_ff @(posedge ref_clk or negedge ref_rst_n) begin
        if (!ref_rst_n) q <= '0;
        else            q <= d;
    end

    assign fail_status_o = q.fail;
    assign irq_flag_o    = q.flag;
    assign irq_o         = q.flag & irq_en;
    assign evt_o         = q.evt;

    // R2
    osc_off_quiet_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !osc_en |=> !fail_status_o);
    // R3
    sleep_quiet_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        !osc_req |=> !fail_status_o);
    // R4
    blank_hold_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (q.run && q.blank != '0) |=> !$rose(fail_status_o));
    // R5
    win_range_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        q.win <= WIN_LAST);
    // R6
    fail_sets_flag_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        window_bad |=> (irq_flag_o && fail_status_o));
    // R8
    clear_flag_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        (flag_clr && !window_bad) |=> !irq_flag_o);
    // R10
    evt_on_rise_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        evt_o |-> ($rose(fail_status_o) && $past(evt_en)));
    // R10
    evt_single_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        evt_o |=> !evt_o);
    // R11
    safe_no_evt_chk: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
        on_safe_clk |=> !evt_o);
endmodule

// File: tb/osc_activity_monitor_tb_top.sv
`timescale 1ns/1ps
module osc_activity_monitor_tb_top;
    localparam int STARTUP_W = 8;
    localparam int N_VEC     = 10;

    logic ref_clk = 1'b0;
    logic ref_rst_n = 1'b0;
    logic mon_gen = 1'b0;
    logic mon_gate = 1'b0;
    logic mon_clk;
    logic osc_en = 1'b0, mon_en = 1'b0, osc_req = 1'b0;
    logic [STARTUP_W-1:0] startup_cnt = 8'd4;
    logic irq_en = 1'b0, evt_en = 1'b0, on_safe_clk = 1'b0, flag_clr = 1'b0;
    logic fail_status_o, irq_flag_o, irq_o, evt_o;

    int n_chk = 0;
    int n_bad = 0;
    int evt_total = 0;
    bit done = 1'b0;

    always #4 ref_clk = ~ref_clk;      // 125 MHz
    always #1.5 mon_gen = ~mon_gen;    // monitored clock, ~333 MHz
    assign mon_clk = mon_gen & mon_gate;

    always @(negedge ref_clk) if (evt_o) evt_total++;

    osc_activity_monitor #(
        .WIN_CYCLES (4), .STARTUP_W (STARTUP_W), .SYNC_STAGES (2)
    ) dut_i (
        .ref_clk, .ref_rst_n, .mon_clk, .osc_en, .mon_en, .osc_req,
        .startup_cnt, .irq_en, .evt_en, .on_safe_clk, .flag_clr,
        .fail_status_o, .irq_flag_o, .irq_o, .evt_o
    );

    // {clr, clk_on, osc_en, mon_en, osc_req, irq_en, evt_en, on_safe}
    // {wait cycles} {exp fail, exp flag, exp irq, exp event count}
    localparam logic [19:0] VEC [N_VEC] = '{
        {8'b0100_0000, 8'd20, 4'b0000},
        {8'b0111_1110, 8'd30, 4'b0000},
        {8'b0011_1110, 8'd20, 4'b1111},
        {8'b0111_1110, 8'd20, 4'b0110},
        {8'b1111_1010, 8'd20, 4'b0000},
        {8'b0011_1011, 8'd20, 4'b1100},
        {8'b1001_1010, 8'd20, 4'b0000},
        {8'b1011_0110, 8'd20, 4'b0000},
        {8'b0010_1110, 8'd20, 4'b0000},
        {8'b0011_1110, 8'd20, 4'b1111}
    };

    function automatic string vec_tag(int i);
        case (i)
            0: return "R1 monitor off";
            1: return "R5 healthy windows";
            2: return "R6 R9 R10 clock stopped";
            3: return "R7 recovery";
            4: return "R8 flag cleared";
            5: return "R11 safe clock, R9 irq gated";
            6: return "R2 oscillator disabled";
            7: return "R3 suspended";
            8: return "R1 monitor enable low";
            default: return "R10 restart fails";
        endcase
    endfunction

    task automatic check(string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", what, act, exp);
        end
    endtask

    task automatic check_int(string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 190000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got hung expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge ref_clk);
        // R1: reset state
        check("R1 reset fail", fail_status_o, 1'b0);
        check("R1 reset flag", irq_flag_o, 1'b0);
        check("R1 reset irq", irq_o, 1'b0);
        check("R1 reset evt", evt_o, 1'b0);
        ref_rst_n = 1'b1;
        @(negedge ref_clk);

        for (int i = 0; i < N_VEC; i++) begin
            logic [19:0] v;
            int base;
            v = VEC[i];
            mon_gate    = v[18];
            osc_en      = v[17];
            mon_en      = v[16];
            osc_req     = v[15];
            irq_en      = v[14];
            evt_en      = v[13];
            on_safe_clk = v[12];
            base        = evt_total;
            if (v[19]) begin
                flag_clr = 1'b1;
                @(negedge ref_clk);
                flag_clr = 1'b0;
            end
            repeat (int'(v[11:4])) @(negedge ref_clk);
            check({vec_tag(i), " fail"}, fail_status_o, v[3]);
            check({vec_tag(i), " flag"}, irq_flag_o, v[2]);
            check({vec_tag(i), " irq"}, irq_o, v[1]);
            check_int({vec_tag(i), " events"}, evt_total - base, int'(v[0]));
        end

        // R8: clear during persistent failure, failure sets the flag again
        flag_clr = 1'b1;
        @(negedge ref_clk);
        flag_clr = 1'b0;
        repeat (8) @(negedge ref_clk);
        check("R8 flag re-set by ongoing failure", irq_flag_o, 1'b1);

        // R1: reset in the middle of a failure
        ref_rst_n = 1'b0;
        @(negedge ref_clk);
        check("R1 reset clears fail", fail_status_o, 1'b0);
        check("R1 reset clears flag", irq_flag_o, 1'b0);

        // R4: blanking interval of 40 cycles with the clock stopped
        osc_en = 1'b0;
        startup_cnt = 8'd40;
        ref_rst_n = 1'b1;
        repeat (2) @(negedge ref_clk);
        osc_en = 1'b1;
        repeat (30) @(negedge ref_clk);
        check("R4 no failure during blanking", fail_status_o, 1'b0);
        check("R4 no flag during blanking", irq_flag_o, 1'b0);
        repeat (26) @(negedge ref_clk);
        check("R4 failure after blanking", fail_status_o, 1'b1);

        // R7: recovery after clock returns, flag stays
        mon_gate = 1'b1;
        repeat (20) @(negedge ref_clk);
        check("R7 status recovers", fail_status_o, 1'b0);
        check("R7 flag stays sticky", irq_flag_o, 1'b1);

        finish_run();
    end
endmodule